// File: doc/BRIEF.md
# Sticky Interrupt Status Register

This block gathers a small set of interrupt sources into a status register that the host reads and that clears when read. The sources are an output-port sample slip, a channel-status buffer transfer (high for the whole transfer) and a receiver error. When a source fires, its status bit is set and stays set until the host reads the register. A companion mask register chooses which sources may set their bits. A masked bit always reads as zero. A single active-high interrupt line is raised while any status bit is set.

A mode setting selects how sources are seen. In edge mode, a bit is set on a rising edge of its source. In level mode, a bit is set in every cycle its source is high. Because of this, a read in level mode cannot clear a bit whose source is still high.

The host reads through a single-cycle read strobe. The read data is the register value present in the strobe cycle. The clear takes effect at the clock edge that ends that cycle. An event in the strobe cycle is applied after the clear, so it is never lost. Mask and mode writes take effect in the same update as the write.

Top module: `irq_status_reg`

## Requirements
- R1: While reset is active, and directly after it, `rd_data_o` is 000, `irq_o` is 0, the mask is 000 (every source masked) and the mode is edge.
- R2: In edge mode, a bit is set at the clock edge that ends a cycle where its source is 1, its source was 0 in the previous cycle (taken as 0 before the first cycle after reset), and its mask bit is 1.
- R3: A set bit stays 1 in later cycles when no read strobe occurs, even after its source returns to 0.
- R4: In edge mode, a read strobe in cycle t shows the current value on `rd_data_o` in cycle t. In cycle t+1, every bit is 0 except those set by a new rising edge in cycle t.
- R5: In level mode, a bit is 1 in the cycle after any cycle where its source and mask bit are both 1. This holds even when a read strobe occurs in that cycle.
- R6: A source event in the same cycle as a read strobe leaves its bit at 1 after the clear.
- R7: A bit whose mask bit is 0 reads 0. Writing a 0 to a mask bit clears that status bit at the same edge, and it stays 0 after re-enabling until a new event occurs.
- R8: `irq_o` is 1 exactly when `rd_data_o` is nonzero (active-high OR of the status bits).
- R9: Bit 0 is the output-port slip, bit 1 is the buffer transfer, and bit 2 is the receiver error. The bits act independently of one another.
- R10: `mode_wdata_i` = 1 selects level mode and 0 selects edge mode. Mask and mode writes apply to the update at the edge ending the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt sources: bit 0 slip, bit 1 buffer transfer, bit 2 receiver error |
| rd_i | input | 1 | Single-cycle read strobe; clears the register |
| mask_we_i | input | 1 | Mask register write enable |
| mask_wdata_i | input | NUM_SRC | New mask value, 1 = source enabled |
| mode_we_i | input | 1 | Mode register write enable |
| mode_wdata_i | input | 1 | New mode, 1 = level, 0 = edge |
| rd_data_o | output | NUM_SRC | Current status value |
| irq_o | output | 1 | Interrupt request, high while any status bit is set |

## Verification
On every cycle, the assertions check the following: the interrupt line matches the status value; masked bits read zero after a mask write; set bits are held when no read occurs; edge and level setting work as specified; and a read in edge mode clears every bit except new rising edges. Only the bench scenarios can show the reset values, the loss-free handling of an event that coincides with a read, the need for a fresh event after a bit is re-enabled, and the independence of the three bit positions across every mask and mode combination.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

    localparam int IRQ_NUM_SRC = 3;

    localparam int IRQ_BIT_SLIP  = 0;
    localparam int IRQ_BIT_XFER  = 1;
    localparam int IRQ_BIT_RXERR = 2;

    typedef enum logic {
        IRQ_MODE_EDGE  = 1'b0,
        IRQ_MODE_LEVEL = 1'b1
    } irq_mode_e;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_status_pkg::*;
#(
    parameter int NUM_SRC = IRQ_NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_we_i,
    input  logic [NUM_SRC-1:0] mask_wdata_i,
    input  logic               mode_we_i,
    input  logic               mode_wdata_i,
    output logic [NUM_SRC-1:0] mask_nx_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               level_nx_o,
    output logic               level_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        irq_mode_e          mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (mask_we_i) begin
            cfg_d.mask = mask_wdata_i;
        end
        if (mode_we_i) begin
            cfg_d.mode = mode_wdata_i ? IRQ_MODE_LEVEL : IRQ_MODE_EDGE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mask: '0, mode: IRQ_MODE_EDGE};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mask_nx_o  = cfg_d.mask;
    assign mask_o     = cfg_q.mask;
    assign level_nx_o = (cfg_d.mode == IRQ_MODE_LEVEL);
    assign level_o    = (cfg_q.mode == IRQ_MODE_LEVEL);

endmodule

// File: rtl/irq_src_sampler.sv
module irq_src_sampler
    import irq_status_pkg::*;
#(
    parameter int NUM_SRC = IRQ_NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    output logic [NUM_SRC-1:0] prev_o,
    output logic [NUM_SRC-1:0] rise_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d      = smp_q;
        smp_d.prev = src_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '{prev: '0};
        end else begin
            smp_q <= smp_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_rise
            assign rise_o[g] = src_i[g] & ~smp_q.prev[g];
        end
    endgenerate

    assign prev_o = smp_q.prev;

endmodule

// File: rtl/irq_status_bits.sv
module irq_status_bits
    import irq_status_pkg::*;
#(
    parameter int NUM_SRC = IRQ_NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] rise_i,
    input  logic               rd_i,
    input  logic [NUM_SRC-1:0] mask_nx_i,
    input  logic               level_nx_i,
    output logic [NUM_SRC-1:0] status_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] status;
    } st_t;

    st_t                st_d, st_q;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] keep_vec;

    always_comb begin
        st_d     = st_q;
        set_vec  = level_nx_i ? src_i : rise_i;
        keep_vec = rd_i ? '0 : st_q.status;
        // clear first, then apply events of this cycle, then mask
        st_d.status = (keep_vec | set_vec) & mask_nx_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{status: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_status_pkg::*;
#(
    parameter int NUM_SRC = IRQ_NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               rd_i,
    input  logic               mask_we_i,
    input  logic [NUM_SRC-1:0] mask_wdata_i,
    input  logic               mode_we_i,
    input  logic               mode_wdata_i,
    output logic [NUM_SRC-1:0] rd_data_o,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] mask_nx;
    logic [NUM_SRC-1:0] mask_q;
    logic               level_nx;
    logic               level_q;
    logic [NUM_SRC-1:0] prev_q;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] status;

    irq_cfg_regs #(.NUM_SRC(NUM_SRC)) cfg_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mask_we_i    (mask_we_i),
        .mask_wdata_i (mask_wdata_i),
        .mode_we_i    (mode_we_i),
        .mode_wdata_i (mode_wdata_i),
        .mask_nx_o    (mask_nx),
        .mask_o       (mask_q),
        .level_nx_o   (level_nx),
        .level_o      (level_q)
    );

    irq_src_sampler #(.NUM_SRC(NUM_SRC)) smp_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .prev_o (prev_q),
        .rise_o (rise)
    );

    irq_status_bits #(.NUM_SRC(NUM_SRC)) bits_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .rise_i     (rise),
        .rd_i       (rd_i),
        .mask_nx_i  (mask_nx),
        .level_nx_i (level_nx),
        .status_o   (status)
    );

    assign rd_data_o = status;
    assign irq_o     = |status;

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
    parameter int NUM_SRC = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic               rd_i,
    input logic               mask_we_i,
    input logic [NUM_SRC-1:0] mask_wdata_i,
    input logic               mode_we_i,
    input logic [NUM_SRC-1:0] rd_data_o,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] mask_q,
    input logic               level_q,
    input logic [NUM_SRC-1:0] prev_q
);

    // R8
    irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (rd_data_o != '0));

    // R7
    mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we_i |=> ((rd_data_o & ~$past(mask_wdata_i)) == '0));

    // R3
    hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && !mask_we_i && !mode_we_i)
        |=> ((rd_data_o & $past(rd_data_o)) == $past(rd_data_o)));

    // R2
    edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_q && !mask_we_i && !mode_we_i)
        |=> ((rd_data_o & $past(src_i & ~prev_q & mask_q)) == $past(src_i & ~prev_q & mask_q)));

    // R5
    level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q && !mask_we_i && !mode_we_i)
        |=> ((rd_data_o & $past(src_i & mask_q)) == $past(src_i & mask_q)));

    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !level_q && !mask_we_i && !mode_we_i)
        |=> (rd_data_o == $past(src_i & ~prev_q & mask_q)));

endmodule

bind irq_status_reg irq_status_chk #(.NUM_SRC(NUM_SRC)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_i        (src_i),
    .rd_i         (rd_i),
    .mask_we_i    (mask_we_i),
    .mask_wdata_i (mask_wdata_i),
    .mode_we_i    (mode_we_i),
    .rd_data_o    (rd_data_o),
    .irq_o        (irq_o),
    .mask_q       (mask_q),
    .level_q      (level_q),
    .prev_q       (prev_q)
);

// File: tb/irq_status_reg_tb_top.sv
`timescale 1ns/1ps
module irq_status_reg_tb_top;

    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_i = '0;
    logic         rd_i = 1'b0;
    logic         mask_we_i = 1'b0;
    logic [N-1:0] mask_wdata_i = '0;
    logic         mode_we_i = 1'b0;
    logic         mode_wdata_i = 1'b0;
    logic [N-1:0] rd_data_o;
    logic         irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [N-1:0] m_status = '0;
    logic [N-1:0] m_prev = '0;
    logic [N-1:0] m_mask = '0;
    logic         m_level = 1'b0;
    logic [15:0]  lfsr = 16'hACE1;

    always #2 clk = ~clk;

    irq_status_reg #(.NUM_SRC(N)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_i        (src_i),
        .rd_i         (rd_i),
        .mask_we_i    (mask_we_i),
        .mask_wdata_i (mask_wdata_i),
        .mode_we_i    (mode_we_i),
        .mode_wdata_i (mode_wdata_i),
        .rd_data_o    (rd_data_o),
        .irq_o        (irq_o)
    );

    task automatic check_val(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // compare outputs with the model, then advance the model by one cycle
    task automatic cyc(input logic [N-1:0] src, input logic rd,
                       input logic mwe, input logic [N-1:0] mdat,
                       input logic lwe, input logic ldat, input string tag);
        logic [N-1:0] set_v;
        @(negedge clk);
        src_i = src; rd_i = rd; mask_we_i = mwe; mask_wdata_i = mdat;
        mode_we_i = lwe; mode_wdata_i = ldat;
        #1;
        check_val(tag, rd_data_o, m_status);
        check_val({tag, "/R8"}, {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, (m_status != '0)});
        if (mwe) m_mask = mdat;
        if (lwe) m_level = ldat;
        set_v    = m_level ? src : (src & ~m_prev);
        m_status = ((rd ? '0 : m_status) | set_v) & m_mask;
        m_prev   = src;
    endtask

    task automatic idle(input logic [N-1:0] src, input string tag);
        cyc(src, 1'b0, 1'b0, '0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        #5;
        check_val("R1 status in reset", rd_data_o, '0);
        check_val("R1 irq in reset", {{(N-1){1'b0}}, irq_o}, '0);
        @(negedge clk); rst_n = 1'b1;
        // R1: mask resets to zero, so a source edge sets nothing
        idle(3'b111, "R1 masked after reset");
        idle(3'b000, "R1 masked after reset");
        check_val("R1 no latch while masked", rd_data_o, '0);

        // R10: enable all, edge mode
        cyc(3'b000, 1'b0, 1'b1, 3'b111, 1'b1, 1'b0, "R10 cfg write");
        // R2/R9: rising edge on slip only
        idle(3'b001, "R2 edge");
        idle(3'b001, "R2 held");
        check_val("R9 slip is bit0", rd_data_o, 3'b001);
        // R3: source falls, bit stays
        idle(3'b000, "R3 sticky");
        idle(3'b000, "R3 sticky");
        check_val("R3 still set", rd_data_o, 3'b001);
        // R4: read clears
        cyc(3'b000, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R4 read data");
        idle(3'b000, "R4 cleared");
        check_val("R4 zero after read", rd_data_o, 3'b000);
        // R2: held-high source does not re-set in edge mode
        idle(3'b100, "R9 rxerr edge");
        cyc(3'b100, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R4 read while held");
        idle(3'b100, "R2 no re-set");
        check_val("R2 held source no retrigger", rd_data_o, 3'b000);
        // R6: new edge in read cycle survives
        idle(3'b000, "R6 prep");
        idle(3'b010, "R6 xfer edge");
        cyc(3'b100, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R6 read with event");
        idle(3'b000, "R6 after");
        check_val("R6 event kept", rd_data_o, 3'b100);

        // R5: level mode, read with source high keeps bit
        cyc(3'b010, 1'b1, 1'b0, '0, 1'b1, 1'b1, "R5 to level");
        cyc(3'b010, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R5 read while high");
        idle(3'b000, "R5 kept");
        check_val("R5 level bit stays", rd_data_o, 3'b010);
        cyc(3'b000, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R5 read source low");
        idle(3'b000, "R5 cleared");
        check_val("R5 cleared when source low", rd_data_o, 3'b000);

        // R7: mask write clears bit, stays clear after re-enable
        idle(3'b101, "R7 set");
        cyc(3'b000, 1'b0, 1'b1, 3'b011, 1'b0, 1'b0, "R7 mask bit2");
        cyc(3'b000, 1'b0, 1'b1, 3'b111, 1'b0, 1'b0, "R7 masked reads 0");
        idle(3'b000, "R7 re-enabled");
        check_val("R7 no resurrection", rd_data_o, 3'b001);
        cyc(3'b000, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R7 flush");

        // R9: sweep of every mode and mask with pseudo-random traffic
        for (int md = 0; md < 2; md++) begin
            for (int mk = 0; mk < 8; mk++) begin
                cyc(3'b000, 1'b1, 1'b1, mk[2:0], 1'b1, md[0], "R10 sweep cfg");
                for (int k = 0; k < 48; k++) begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    cyc(lfsr[2:0], (lfsr[7:5] == 3'b000), 1'b0, '0, 1'b0, 1'b0, "R9 sweep");
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule